// File: doc/BRIEF.md
# Nibble Serial Register Access Engine

This block is the bus master for a three-wire serial link to a clock/calendar device. Each access reads or writes a single 4-bit register at a 4-bit register index. The host side gives a one-cycle start pulse together with a read/write select, the register index and the write nibble. When the access is over, the block pulses done and, after a read, shows the fetched nibble on its read data output.

On the pin side the block drives a serial clock, a serial data output and an output-enable for the shared data line, and it samples the incoming data line. Every access is one frame of sixteen bit periods. The frame opens with a control nibble that marks the address phase and the transfer direction. The register index follows, most significant bit first. A write then sends a second control nibble that marks the data phase, followed by the data. A read instead releases the line, lets four bit periods pass unused and then shifts in four data bits. Chip enable is handled outside this block.

Top module: `nib_serial_master`

## Requirements
- R1: After reset, sck, sdo_en, done and rdata are all 0, and the block is idle.
- R2: A read frame drives, on its first eight bit periods, 1,1,1,0 and then addr[3], addr[2], addr[1], addr[0], with sdo_en high for those eight periods.
- R3: A write frame drives 1,0,1,0, then addr[3..0], then 1,0,0,1, then wdata[3..0] in MSB-first order, with sdo_en high for all sixteen bit periods.
- R4: In a read frame, sdo_en is low for bit periods 8 to 15. The values sampled in periods 8 to 11 are discarded. The values sampled in periods 12 to 15 form rdata, with period 12 giving rdata[3] and period 15 giving rdata[0].
- R5: Each bit period lasts DIV_RATIO clock cycles: sck is low for the first DIV_RATIO/2 cycles and high for the rest. sdo and sdo_en change only while sck is low, and sdi is sampled as sck rises.
- R6: Each frame has exactly sixteen sck rising edges. done is high for one cycle, 16*DIV_RATIO+1 cycles after the cycle in which start was accepted, and sck and sdo_en are low in that cycle.
- R7: A start pulse that arrives while a frame is in progress is ignored: the frame in progress is unchanged and no extra frame or done pulse follows.
- R8: rdata changes only when a read frame completes. A write frame leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an access |
| rd_sel | input | 1 | 1 for a read, 0 for a write; captured with start |
| addr | input | 4 | Register index; captured with start |
| wdata | input | 4 | Write nibble; captured with start |
| rdata | output | 4 | Nibble from the most recent completed read |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data toward the device |
| sdo_en | output | 1 | High while the master drives the data line |
| sdi | input | 1 | Serial data from the device |

## Verification
The main function is exercised with a table of write/read pairs. The pairs use indices 0, 3, 10, 12 and 15 and nibbles that include all-zeros and all-ones, so a reversed bit order, a stuck bit or a swapped nibble shows up as a decode mismatch in the device model. During the four discarded read periods the device model drives the inverse of the stored nibble, so a capture window shifted by four periods returns the complement and cannot match the expected value. Directed tests check that rdata holds across a write and that a start pulse in the middle of a frame leaves the frame intact.

// File: rtl/nib_serial_master.sv
module nib_serial_master #(
  parameter int DIV_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_sel,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  output logic       done,
  output logic       sck,
  output logic       sdo,
  output logic       sdo_en,
  input  logic       sdi
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam int LAST = 15;

  logic          busy;
  logic          is_rd;
  logic [CW-1:0] div_cnt;
  logic [3:0]    bit_idx;
  logic [15:0]   frame;
  logic [3:0]    shreg;

  wire at_rise = (div_cnt == CW'(HALF - 1));
  wire at_end  = (div_cnt == CW'(DIV_RATIO - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      frame   <= '0;
      shreg   <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          is_rd   <= rd_sel;
          div_cnt <= '0;
          bit_idx <= '0;
          frame   <= rd_sel ? {4'b1110, addr, 8'h00}
                            : {4'b1010, addr, 4'b1001, wdata};
        end
      end else begin
        if (at_rise && is_rd && bit_idx >= 4'd12)
          shreg <= {shreg[2:0], sdi};
        if (at_end) begin
          div_cnt <= '0;
          bit_idx <= bit_idx + 4'd1;
          if (bit_idx == 4'(LAST)) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (is_rd) rdata <= shreg;
          end
        end else begin
          div_cnt <= div_cnt + CW'(1);
        end
      end
    end
  end

  assign sck    = busy & (div_cnt >= CW'(HALF));
  assign sdo    = busy & frame[4'(LAST) - bit_idx];
  assign sdo_en = busy & ~(is_rd & bit_idx[3]);
endmodule

// File: rtl/nib_serial_master_chk.sv
module nib_serial_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       sck,
  input logic       sdo,
  input logic       sdo_en,
  input logic [3:0] rdata
);
  logic       sck_q, busy_q;
  logic [4:0] nrise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
      nrise  <= '0;
    end else begin
      sck_q  <= sck;
      busy_q <= busy;
      if (busy && !busy_q) nrise <= '0;
      else if (sck && !sck_q) nrise <= nrise + 5'd1;
    end
  end

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nrise == 5'd16) && !sck && !sdo_en);
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> ($stable(sdo) && $stable(sdo_en)));
  p_release_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_en) |-> !sck);
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);
endmodule

bind nib_serial_master nib_serial_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .sck(sck), .sdo(sdo), .sdo_en(sdo_en), .rdata(rdata)
);

// File: tb/nib_serial_master_test.sv
module nib_serial_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NVEC = 10;
  // {rd, addr, wdata, expected rdata}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 4'h3, 4'h9, 4'h0}, {1'b1, 4'h3, 4'h0, 4'h9},
    {1'b0, 4'hC, 4'h5, 4'h0}, {1'b1, 4'hC, 4'h0, 4'h5},
    {1'b1, 4'h3, 4'h0, 4'h9}, {1'b0, 4'hF, 4'hF, 4'h0},
    {1'b1, 4'hF, 4'h0, 4'hF}, {1'b0, 4'hA, 4'h6, 4'h0},
    {1'b1, 4'hA, 4'h0, 4'h6}, {1'b1, 4'h0, 4'h0, 4'h0}
  };

  logic clk = 0, rst_n = 0, start = 0, rd_sel = 0, sdi;
  logic [3:0] addr = 0, wdata = 0, rdata;
  logic done, sck, sdo, sdo_en;
  int total = 0, bad = 0, wd = 0, hi_viol = 0;

  nib_serial_master #(.DIV_RATIO(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .sck(sck), .sdo(sdo),
    .sdo_en(sdo_en), .sdi(sdi));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] mem [16];
  logic       bits [16];
  logic       ens  [16];
  int         dcnt = 0;

  function automatic logic [3:0] dev_addr();
    return {bits[4], bits[5], bits[6], bits[7]};
  endfunction

  always_comb begin
    sdi = 1'b0;
    if (dcnt >= 8 && dcnt < 12 && bits[1]) sdi = ~mem[dev_addr()][11 - dcnt];
    else if (dcnt >= 12 && dcnt < 16 && bits[1]) sdi = mem[dev_addr()][15 - dcnt];
  end

  always @(posedge sck) begin
    if (dcnt < 16) begin
      bits[dcnt] = sdo;
      ens[dcnt]  = sdo_en;
    end
    if (dcnt == 15 && {bits[0], bits[1], bits[2], bits[3]} == 4'b1010 &&
        {bits[8], bits[9], bits[10], bits[11]} == 4'b1001)
      mem[dev_addr()] = {bits[12], bits[13], bits[14], bits[15]};
    dcnt = dcnt + 1;
  end

  always @(sdo or sdo_en) if (sck) hi_viol++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit rd, input logic [3:0] a, input logic [3:0] d,
                        input bit poke, output int cyc);
    @(negedge clk);
    rd_sel = rd; addr = a; wdata = d; start = 1; dcnt = 0;
    @(negedge clk);
    start = 0; cyc = 1;
    while (!done) begin
      if (poke && cyc == 20) begin start = 1; rd_sel = ~rd; addr = ~a; wdata = ~d; end
      else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
  endtask

  task automatic check_frame(input bit rd, input logic [3:0] a, input logic [3:0] d, input string tag);
    logic [15:0] obs, oen, exp, een;
    for (int i = 0; i < 16; i++) begin obs[15-i] = bits[i]; oen[15-i] = ens[i]; end
    if (rd) begin
      exp = {4'b1110, a, 8'h00}; een = 16'hFF00;
      check(obs[15:8] == exp[15:8], {tag, " R2 read header"}, obs[15:8], exp[15:8]);
      check(oen == een, {tag, " R4 read enable"}, oen, een);
    end else begin
      exp = {4'b1010, a, 4'b1001, d}; een = 16'hFFFF;
      check(obs == exp, {tag, " R3 write frame"}, obs, exp);
      check(oen == een, {tag, " R3 write enable"}, oen, een);
    end
    check(dcnt == 16, {tag, " R6 rise count"}, dcnt, 16);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int cyc;
    logic [3:0] held;
    for (int i = 0; i < 16; i++) begin mem[i] = 4'h0; bits[i] = 0; ens[i] = 0; end
    repeat (3) @(negedge clk);
    check({sck, sdo_en, done} == 3'b000, "R1 idle pins", {sck, sdo_en, done}, 0);
    check(rdata == 4'h0, "R1 rdata reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][12], VEC[v][11:8], VEC[v][7:4], 1'b0, cyc);
      check_frame(VEC[v][12], VEC[v][11:8], VEC[v][7:4], $sformatf("vec%0d", v));
      check(cyc == 16*DIV + 1, "R6 R5 frame cycles", cyc, 16*DIV + 1);
      if (VEC[v][12])
        check(rdata == VEC[v][3:0], "R4 read data", rdata, VEC[v][3:0]);
    end

    held = rdata;
    access(1'b0, 4'h5, 4'hB, 1'b0, cyc);
    check(rdata == held, "R8 rdata held over write", rdata, held);
    check(mem[5] == 4'hB, "R3 device stored", mem[5], 4'hB);

    access(1'b0, 4'h6, 4'h2, 1'b1, cyc);
    check_frame(1'b0, 4'h6, 4'h2, "poke");
    check(cyc == 16*DIV + 1, "R7 frame length with stray start", cyc, 16*DIV + 1);
    begin
      int extra = 0;
      @(negedge clk);
      for (int i = 0; i < 4*DIV; i++) begin
        if (done || sck || sdo_en) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R7 no extra frame", extra, 0);
    end
    check(mem[9] == 4'h0, "R7 stray write absent", mem[9], 0);

    access(1'b1, 4'h6, 4'h0, 1'b0, cyc);
    check(rdata == 4'h2, "R4 read after stray", rdata, 4'h2);
    check(hi_viol == 0, "R5 pins stable while sck high", hi_viol, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule